// File: doc/BRIEF.md
# Two-Section Decade Divider

This block is a four-bit counter split into two sections that count on their own. The low bit is a toggle stage that halves its count input. The upper bits form a wrap-around stage that divides its own count input by five. Each section advances on a falling edge of its count input. Both count inputs are sampled on a shared system clock, so the block stays fully synchronous while it still behaves like a pair of cascadable ripple stages. When the low bit is wired externally to the upper section's count input, the four outputs run through BCD 0 to 9 and then wrap. The result is a divide-by-ten.

Two override controls act on the outputs at once, without waiting for a clock. The clear control shows zero. The preset control shows nine, and it takes priority when both are active. While either override is held, the internal state is loaded with the forced value on every clock. The count therefore resumes from that value once the override is released. Count edges that arrive during an override are discarded. Parameters set the modulus of the upper section and the depth of the input synchronisers.

Top module: `decade_ripple_div`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other stimulus, `q_o` reads 0000.
- R2: A high-to-low transition on `tick2_i` inverts `q_o[0]`; a low-to-high transition leaves every output bit unchanged.
- R3: Each high-to-low transition on `tick5_i` moves `q_o[3:1]` along 000, 001, 010, 011, 100 and then back to 000; the field never holds a value above 100.
- R4: The sections are independent: edges on `tick5_i` never change `q_o[0]`, and edges on `tick2_i` never change `q_o[3:1]`.
- R5: With `tick5_i` driven from `q_o[0]`, consecutive `tick2_i` pulses make `q_o` read k mod 10 after pulse k; 100 pulses produce exactly ten wraps from 1001 to 0000.
- R6: While `preset_i` is high, `q_o` reads 1001 in the same cycle, whatever `clr_i` is doing; after release, counting continues from 1001.
- R7: While `clr_i` is high and `preset_i` is low, `q_o` reads 0000 in the same cycle; after release, counting continues from 0000.
- R8: Count edges that occur while `preset_i` or `clr_i` is high are ignored; the value on release equals the forced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both count inputs |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| tick2_i | input | 1 | Count input of the toggle section; active on falling edge |
| tick5_i | input | 1 | Count input of the divide-by-five section; active on falling edge |
| clr_i | input | 1 | Override to zero, active high |
| preset_i | input | 1 | Override to nine, active high, wins over `clr_i` |
| q_o | output | 4 | Count; bit 0 is the toggle section, bits 3:1 the upper section |

## Verification
The toggle section and the divide-by-five section are each driven alone with full pulses. Observing the other section at the same time shows whether the two are truly independent or are accidentally chained. The upper section is pulsed seven times, which passes its wrap point and distinguishes a modulus of five from four, six or eight. A hundred-pulse cascaded run compares every count against k mod 10 and counts the wraps, which exposes any miscounted BCD step. The override phases toggle the count inputs while clear, preset or both are held. These phases tell apart the forced value, the priority between the two controls, edge suppression, and the resume value.

// File: rtl/drdiv_pkg.sv
package drdiv_pkg;

   // Override state that the top decodes from the two force controls.
   typedef enum logic [1:0] {
      FORCE_NONE = 2'd0,
      FORCE_CLR  = 2'd1,
      FORCE_SET  = 2'd2
   } force_e;

   // Bits needed to hold 0 .. n-1.
   function automatic int unsigned stage_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/drdiv_edge_sampler.sv
module drdiv_edge_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall_o
);
   logic sampled;
   logic prev_q;

   generate
      if (SYNC_STAGES > 4) begin : g_bad_depth
         $error("drdiv_edge_sampler: SYNC_STAGES must be 0..4");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (SYNC_STAGES == 1) begin
               chain_q <= din;
            end else begin
               chain_q <= {chain_q[SYNC_STAGES-2:0], din};
            end
         end
         assign sampled = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= sampled;
      end
   end

   assign fall_o = prev_q & ~sampled;
endmodule

// File: rtl/drdiv_toggle_stage.sv
module drdiv_toggle_stage
   import drdiv_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  force_e force_i,
   input  logic   step_i,
   output logic   q_o
);
   logic bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
      end else begin
         unique case (force_i)
            FORCE_SET: bit_q <= 1'b1;
            FORCE_CLR: bit_q <= 1'b0;
            default:   if (step_i) bit_q <= ~bit_q;
         endcase
      end
   end

   assign q_o = bit_q;
endmodule

// File: rtl/drdiv_modn_stage.sv
module drdiv_modn_stage
   import drdiv_pkg::*;
#(
   parameter int unsigned MODULUS = 5,
   localparam int unsigned W      = stage_width(MODULUS)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  force_e       force_i,
   input  logic         step_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_next;

   generate
      if (MODULUS < 2) begin : g_bad_mod
         $error("drdiv_modn_stage: MODULUS must be at least 2");
      end
   endgenerate

   always_comb begin
      if (cnt_q == LAST) begin
         cnt_next = '0;
      end else begin
         cnt_next = cnt_q + W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (force_i)
            FORCE_SET: cnt_q <= LAST;
            FORCE_CLR: cnt_q <= '0;
            default:   if (step_i) cnt_q <= cnt_next;
         endcase
      end
   end

   assign q_o = cnt_q;
endmodule

// File: rtl/decade_ripple_div.sv
module decade_ripple_div
   import drdiv_pkg::*;
#(
   parameter int unsigned DIV_HI      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned HW         = stage_width(DIV_HI),
   localparam int unsigned QW         = HW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick2_i,
   input  logic          tick5_i,
   input  logic          clr_i,
   input  logic          preset_i,
   output logic [QW-1:0] q_o
);
   localparam logic [QW-1:0] SET_VAL = {HW'(DIV_HI - 1), 1'b1};

   force_e       force_w;
   logic         fall2_w;
   logic         fall5_w;
   logic         lo_q;
   logic [HW-1:0] hi_q;

   // Preset outranks clear.
   always_comb begin
      if (preset_i) begin
         force_w = FORCE_SET;
      end else if (clr_i) begin
         force_w = FORCE_CLR;
      end else begin
         force_w = FORCE_NONE;
      end
   end

   drdiv_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (tick2_i),
      .fall_o (fall2_w)
   );

   drdiv_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp5 (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (tick5_i),
      .fall_o (fall5_w)
   );

   drdiv_toggle_stage u_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .force_i (force_w),
      .step_i  (fall2_w),
      .q_o     (lo_q)
   );

   drdiv_modn_stage #(.MODULUS(DIV_HI)) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .force_i (force_w),
      .step_i  (fall5_w),
      .q_o     (hi_q)
   );

   // Overrides reach the outputs without a clock edge.
   always_comb begin
      unique case (force_w)
         FORCE_SET: q_o = SET_VAL;
         FORCE_CLR: q_o = '0;
         default:   q_o = {hi_q, lo_q};
      endcase
   end
endmodule

// File: rtl/decade_ripple_div_chk.sv
module decade_ripple_div_chk #(
   parameter int unsigned DIV_HI = 5,
   parameter int unsigned HW     = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr_i,
   input logic          preset_i,
   input logic          fall2_w,
   input logic          fall5_w,
   input logic [HW:0]   q_o
);
   localparam logic [HW-1:0] HI_LAST = HW'(DIV_HI - 1);

   // R6
   preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preset_i |-> (q_o == {HI_LAST, 1'b1}));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !preset_i) |-> (q_o == '0));

   // R3
   hi_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_o[HW:1] <= HI_LAST);

   // R4
   lo_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_i && !clr_i && !fall2_w) |=>
         (preset_i || clr_i || q_o[0] == $past(q_o[0])));

   // R4
   hi_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_i && !clr_i && !fall5_w) |=>
         (preset_i || clr_i || q_o[HW:1] == $past(q_o[HW:1])));

   // R3
   hi_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_i && !clr_i && fall5_w) |=>
         (preset_i || clr_i ||
          q_o[HW:1] == (($past(q_o[HW:1]) == HI_LAST) ? '0
                                                      : $past(q_o[HW:1]) + HW'(1))));

   // R8
   resume_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (preset_i) |=> (preset_i || clr_i || q_o == {HI_LAST, 1'b1}));
endmodule

bind decade_ripple_div decade_ripple_div_chk #(.DIV_HI(DIV_HI), .HW(HW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_i    (clr_i),
   .preset_i (preset_i),
   .fall2_w  (fall2_w),
   .fall5_w  (fall5_w),
   .q_o      (q_o)
);

// File: tb/decade_ripple_div_tb.sv
module decade_ripple_div_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       t2 = 1'b0;
   logic       t5_drv = 1'b0;
   logic       cascade = 1'b0;
   logic       clr = 1'b0;
   logic       pre = 1'b0;
   logic       t5;
   logic [3:0] q;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   assign t5 = cascade ? q[0] : t5_drv;

   decade_ripple_div u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick2_i  (t2),
      .tick5_i  (t5),
      .clr_i    (clr),
      .preset_i (pre),
      .q_o      (q)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: q_o=%b expected %b", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse2();
      t2 = 1'b1; wait_cyc(5);
      t2 = 1'b0; wait_cyc(10);
   endtask

   task automatic pulse5();
      t5_drv = 1'b1; wait_cyc(5);
      t5_drv = 1'b0; wait_cyc(10);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: q_o=%b expected completion", q);
      finish_run();
   end

   initial begin
      logic [3:0] prev;
      int         wraps;
      wait_cyc(3);
      chk("R1 in reset", q, 4'b0000);
      rst_n = 1'b1; wait_cyc(4);
      chk("R1 after reset", q, 4'b0000);

      // R2: rising edge alone does nothing, falling edge toggles
      t2 = 1'b1; wait_cyc(8);
      chk("R2 rise ignored", q, 4'b0000);
      t2 = 1'b0; wait_cyc(8);
      chk("R2 fall toggles", q, 4'b0001);
      pulse2();
      chk("R2 second toggle", q, 4'b0000);

      // R3 and R4: upper section alone over its wrap point
      for (int k = 1; k <= 7; k++) begin
         pulse5();
         chk("R3 mod-5 step", q, {3'(k % 5), 1'b0});
      end
      // R4: low section pulsed, upper holds
      pulse2();
      chk("R4 tick2 leaves upper", q, {3'(7 % 5), 1'b1});
      pulse5();
      chk("R4 tick5 leaves bit0", q, {3'(8 % 5), 1'b1});

      // R7: clear immediate and persistent
      @(negedge clk); clr = 1'b1; #0.5;
      chk("R7 clear immediate", q, 4'b0000);
      wait_cyc(2); clr = 1'b0; wait_cyc(2);
      chk("R7 clear held after release", q, 4'b0000);

      // R5: cascaded 100 pulses
      cascade = 1'b1; wait_cyc(8);
      wraps = 0;
      for (int k = 1; k <= 100; k++) begin
         prev = q;
         pulse2();
         chk("R5 BCD count", q, 4'(k % 10));
         if (prev == 4'd9 && q == 4'd0) wraps++;
      end
      chk("R5 wrap count", 4'(wraps), 4'd10);
      cascade = 1'b0; wait_cyc(8);

      // R6: preset immediate, wins over clear, resumes from nine
      @(negedge clk); pre = 1'b1; #0.5;
      chk("R6 preset immediate", q, 4'b1001);
      clr = 1'b1; wait_cyc(2);
      chk("R6 preset over clear", q, 4'b1001);
      clr = 1'b0; wait_cyc(1);
      // R8: edges during preset ignored
      t2 = 1'b1; t5_drv = 1'b1; wait_cyc(4);
      t2 = 1'b0; t5_drv = 1'b0; wait_cyc(10);
      pre = 1'b0; wait_cyc(4);
      chk("R8 edges under preset ignored", q, 4'b1001);
      pulse2();
      chk("R6 resume from nine", q, 4'b1000);

      // R8: edges during clear ignored
      clr = 1'b1; wait_cyc(1);
      t2 = 1'b1; t5_drv = 1'b1; wait_cyc(4);
      t2 = 1'b0; t5_drv = 1'b0; wait_cyc(10);
      clr = 1'b0; wait_cyc(4);
      chk("R8 edges under clear ignored", q, 4'b0000);

      // R1: reset mid-count
      pulse5(); pulse2();
      chk("R3 count before reset", q, 4'b0011);
      rst_n = 1'b0; wait_cyc(2);
      chk("R1 reset mid-count", q, 4'b0000);
      rst_n = 1'b1; wait_cyc(2);
      finish_run();
   end
endmodule